// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit sits between a CPU and a memory interface. It turns a 16-bit CPU address into a 24-bit physical address: an 8-bit segment value becomes the upper byte and the CPU address becomes the lower bits. There are two segment registers. The read segment sets the upper byte for memory loads. The write segment sets it for memory stores.

Both segment registers are mapped at the two highest CPU addresses. Loads and stores to those addresses are served inside the unit and never reach memory. Every other address goes out on a memory channel.

The CPU side has a load channel and a store channel. The CPU raises `valid` and holds the address and data steady until the unit raises `ready` for one cycle. On a load, the returned data is valid in that same cycle. The memory side also has a load channel and a store channel, using the ordinary valid/ready rule. Only one CPU transaction is in flight at any time.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset both segment registers hold 0, and `ld_ready_o`, `st_ready_o`, `mem_ld_valid_o` and `mem_st_valid_o` are all low.
- R2: A load from 0xFFFF returns the read segment zero-extended to 16 bits, so bits 15..8 are 0. It raises no memory load.
- R3: A load from 0xFFFE returns the write segment zero-extended to 16 bits. It raises no memory load.
- R4: A load from any other address raises `mem_ld_valid_o` with `mem_ld_addr_o` = {read segment, address}. The CPU `ld_ready_o` rises in the cycle after the memory handshake, and `ld_data_o` then equals the data memory returned.
- R5: A store to 0xFFFF writes `st_data_i[7:0]` into the read segment. Bits 15..8 of the store data are ignored, and no memory store is raised.
- R6: A store to 0xFFFE writes `st_data_i[7:0]` into the write segment. No memory store is raised.
- R7: A store to any other address raises `mem_st_valid_o` with `mem_st_addr_o` = {write segment, address} and the full 16-bit data. `st_ready_o` rises in the cycle after the memory handshake.
- R8: Only one transaction is in flight at a time. When a load and a store are both requested while the unit is idle, the load is served first. The two ready outputs are never high together, and neither are the two memory valid outputs. Each ready pulse lasts one cycle.
- R9: A register access is accepted on the clock edge where the unit is idle and sees `valid` high. Its `ready` is high in the cycle after that edge.
- R10: While a memory request waits for `ready`, its valid stays high and its address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | CPU load request |
| ld_addr_i | input | 16 | CPU load address |
| ld_ready_o | output | 1 | CPU load completion; data valid in this cycle |
| ld_data_o | output | 16 | CPU load data |
| st_valid_i | input | 1 | CPU store request |
| st_addr_i | input | 16 | CPU store address |
| st_data_i | input | 16 | CPU store data |
| st_ready_o | output | 1 | CPU store completion |
| mem_ld_valid_o | output | 1 | Memory load request |
| mem_ld_addr_o | output | 24 | Memory load physical address |
| mem_ld_ready_i | input | 1 | Memory load acknowledge with data |
| mem_ld_data_i | input | 16 | Memory load data |
| mem_st_valid_o | output | 1 | Memory store request |
| mem_st_addr_o | output | 24 | Memory store physical address |
| mem_st_data_o | output | 16 | Memory store data |
| mem_st_ready_i | input | 1 | Memory store acknowledge |

## Verification
The bench builds the unit with its default widths: a 16-bit CPU address, 8-bit segments and 16-bit data. With these widths the full 256-value range of each segment register can be swept. For each value the bench writes both registers with the upper data byte set to a different pattern, reads both back, and issues one memory load and one memory store that carry the segment values in the physical address. Memory latencies of 0 to 3 cycles are applied in turn. The boundary address 0xFFFD, address 0x0000 and simultaneous load and store requests are also exercised.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    XS_IDLE,
    XS_MEM_LD,
    XS_MEM_ST,
    XS_LD_DONE,
    XS_ST_DONE
  } xlate_state_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RSEG,
    SEL_WSEG
  } reg_sel_e;
endpackage

// File: rtl/seg_addr_decode.sv
module seg_addr_decode
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 16
) (
  input  logic [VA_W-1:0] addr_i,
  output reg_sel_e        sel_o
);
  logic top_pair;

  // every bit above bit 0 set: one of the two register slots
  assign top_pair = &addr_i[VA_W-1:1];

  always_comb begin
    if (!top_pair)      sel_o = SEL_NONE;
    else if (addr_i[0]) sel_o = SEL_RSEG;
    else                sel_o = SEL_WSEG;
  end
endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         wr_sel_i,
  input  logic [SEG_W-1:0] wr_data_i,
  output logic [SEG_W-1:0] rseg_o,
  output logic [SEG_W-1:0] wseg_o
);
  localparam int NREG = 2;

  logic [SEG_W-1:0] seg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_seg
    localparam reg_sel_e MY_SEL = (g == 0) ? SEL_RSEG : SEL_WSEG;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             seg_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == MY_SEL)  seg_q[g] <= wr_data_i;
    end
  end

  assign rseg_o = seg_q[0];
  assign wseg_o = seg_q[1];
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_valid_i,
  input  logic         st_valid_i,
  input  reg_sel_e     ld_sel_i,
  input  reg_sel_e     st_sel_i,
  input  logic         mem_ld_ready_i,
  input  logic         mem_st_ready_i,
  output logic         acc_ld_o,
  output logic         acc_st_o,
  output logic         ld_mem_hs_o,
  output logic         mem_ld_valid_o,
  output logic         mem_st_valid_o,
  output logic         ld_ready_o,
  output logic         st_ready_o
);
  xlate_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    acc_ld_o = 1'b0;
    acc_st_o = 1'b0;
    unique case (state_q)
      XS_IDLE: begin
        // load has priority over store
        if (ld_valid_i) begin
          acc_ld_o = 1'b1;
          state_d  = (ld_sel_i == SEL_NONE) ? XS_MEM_LD : XS_LD_DONE;
        end else if (st_valid_i) begin
          acc_st_o = 1'b1;
          state_d  = (st_sel_i == SEL_NONE) ? XS_MEM_ST : XS_ST_DONE;
        end
      end
      XS_MEM_LD:  if (mem_ld_ready_i) state_d = XS_LD_DONE;
      XS_MEM_ST:  if (mem_st_ready_i) state_d = XS_ST_DONE;
      XS_LD_DONE: state_d = XS_IDLE;
      XS_ST_DONE: state_d = XS_IDLE;
      default:    state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= XS_IDLE;
    else         state_q <= state_d;
  end

  assign mem_ld_valid_o = (state_q == XS_MEM_LD);
  assign mem_st_valid_o = (state_q == XS_MEM_ST);
  assign ld_ready_o     = (state_q == XS_LD_DONE);
  assign st_ready_o     = (state_q == XS_ST_DONE);
  assign ld_mem_hs_o    = mem_ld_valid_o && mem_ld_ready_i;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int VA_W   = 16,
  parameter int SEG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_valid_i,
  input  logic [VA_W-1:0]         ld_addr_i,
  output logic                    ld_ready_o,
  output logic [DATA_W-1:0]       ld_data_o,
  input  logic                    st_valid_i,
  input  logic [VA_W-1:0]         st_addr_i,
  input  logic [DATA_W-1:0]       st_data_i,
  output logic                    st_ready_o,
  output logic                    mem_ld_valid_o,
  output logic [SEG_W+VA_W-1:0]   mem_ld_addr_o,
  input  logic                    mem_ld_ready_i,
  input  logic [DATA_W-1:0]       mem_ld_data_i,
  output logic                    mem_st_valid_o,
  output logic [SEG_W+VA_W-1:0]   mem_st_addr_o,
  output logic [DATA_W-1:0]       mem_st_data_o,
  input  logic                    mem_st_ready_i
);
  localparam int PA_W = SEG_W + VA_W;

  reg_sel_e          ld_sel, st_sel;
  logic              acc_ld, acc_st, ld_mem_hs;
  logic [SEG_W-1:0]  rseg, wseg;
  logic [VA_W-1:0]   addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  seg_addr_decode #(.VA_W(VA_W)) u_ld_dec (.addr_i(ld_addr_i), .sel_o(ld_sel));
  seg_addr_decode #(.VA_W(VA_W)) u_st_dec (.addr_i(st_addr_i), .sel_o(st_sel));

  seg_xlate_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ld_valid_i     (ld_valid_i),
    .st_valid_i     (st_valid_i),
    .ld_sel_i       (ld_sel),
    .st_sel_i       (st_sel),
    .mem_ld_ready_i (mem_ld_ready_i),
    .mem_st_ready_i (mem_st_ready_i),
    .acc_ld_o       (acc_ld),
    .acc_st_o       (acc_st),
    .ld_mem_hs_o    (ld_mem_hs),
    .mem_ld_valid_o (mem_ld_valid_o),
    .mem_st_valid_o (mem_st_valid_o),
    .ld_ready_o     (ld_ready_o),
    .st_ready_o     (st_ready_o)
  );

  seg_reg_file #(.SEG_W(SEG_W)) u_segs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (acc_st && st_sel != SEL_NONE),
    .wr_sel_i  (st_sel),
    .wr_data_i (st_data_i[SEG_W-1:0]),
    .rseg_o    (rseg),
    .wseg_o    (wseg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (acc_ld) begin
      addr_q  <= ld_addr_i;
    end else if (acc_st) begin
      addr_q  <= st_addr_i;
      wdata_q <= st_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_q <= '0;
    else if (acc_ld && ld_sel == SEL_RSEG) rdata_q <= DATA_W'(rseg);
    else if (acc_ld && ld_sel == SEL_WSEG) rdata_q <= DATA_W'(wseg);
    else if (ld_mem_hs)                    rdata_q <= mem_ld_data_i;
  end

  // segment registers cannot change while a memory request is pending
  assign mem_ld_addr_o = PA_W'({rseg, addr_q});
  assign mem_st_addr_o = PA_W'({wseg, addr_q});
  assign mem_st_data_o = wdata_q;
  assign ld_data_o     = rdata_q;
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int VA_W   = 16,
  parameter int SEG_W  = 8,
  parameter int DATA_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ld_ready_o,
  input logic [DATA_W-1:0]     ld_data_o,
  input logic                  st_ready_o,
  input logic                  mem_ld_valid_o,
  input logic [SEG_W+VA_W-1:0] mem_ld_addr_o,
  input logic                  mem_ld_ready_i,
  input logic [DATA_W-1:0]     mem_ld_data_i,
  input logic                  mem_st_valid_o,
  input logic [SEG_W+VA_W-1:0] mem_st_addr_o,
  input logic [DATA_W-1:0]     mem_st_data_o,
  input logic                  mem_st_ready_i
);
  assert_mem_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_ld_valid_o && mem_st_valid_o));

  assert_ready_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_ready_o && st_ready_o));

  assert_ld_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ready_o |=> !ld_ready_o);

  assert_st_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ready_o |=> !st_ready_o);

  assert_mem_ld_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ld_valid_o && !mem_ld_ready_i) |=> (mem_ld_valid_o && $stable(mem_ld_addr_o)));

  assert_mem_st_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_st_valid_o && !mem_st_ready_i) |=>
      (mem_st_valid_o && $stable(mem_st_addr_o) && $stable(mem_st_data_o)));

  assert_ld_after_mem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ld_valid_o && mem_ld_ready_i) |=> (ld_ready_o && ld_data_o == $past(mem_ld_data_i)));

  assert_st_after_mem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_st_valid_o && mem_st_ready_i) |=> st_ready_o);

  assert_no_reg_ld_to_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ld_valid_o |-> !(&mem_ld_addr_o[VA_W-1:1]));

  assert_no_reg_st_to_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_st_valid_o |-> !(&mem_st_addr_o[VA_W-1:1]));
endmodule

bind seg_xlate_unit seg_xlate_checker #(.VA_W(VA_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ld_ready_o     (ld_ready_o),
  .ld_data_o      (ld_data_o),
  .st_ready_o     (st_ready_o),
  .mem_ld_valid_o (mem_ld_valid_o),
  .mem_ld_addr_o  (mem_ld_addr_o),
  .mem_ld_ready_i (mem_ld_ready_i),
  .mem_ld_data_i  (mem_ld_data_i),
  .mem_st_valid_o (mem_st_valid_o),
  .mem_st_addr_o  (mem_st_addr_o),
  .mem_st_data_o  (mem_st_data_o),
  .mem_st_ready_i (mem_st_ready_i)
);

// File: tb/seg_xlate_unit_bench.sv
`timescale 1ns/1ps
module seg_xlate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_addr = '0;
  logic        st_valid = 1'b0;
  logic [15:0] st_addr = '0;
  logic [15:0] st_data = '0;
  logic        mem_ld_ready = 1'b0;
  logic [15:0] mem_ld_data = '0;
  logic        mem_st_ready = 1'b0;
  logic        ld_ready_o, st_ready_o, mem_ld_valid_o, mem_st_valid_o;
  logic [15:0] ld_data_o, mem_st_data_o;
  logic [23:0] mem_ld_addr_o, mem_st_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_ready_o(ld_ready_o), .ld_data_o(ld_data_o),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(st_ready_o),
    .mem_ld_valid_o(mem_ld_valid_o), .mem_ld_addr_o(mem_ld_addr_o),
    .mem_ld_ready_i(mem_ld_ready), .mem_ld_data_i(mem_ld_data),
    .mem_st_valid_o(mem_st_valid_o), .mem_st_addr_o(mem_st_addr_o),
    .mem_st_data_o(mem_st_data_o), .mem_st_ready_i(mem_st_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cpu_load(input logic [15:0] a, input bit to_mem, input int lat,
                          input logic [15:0] mdata, input logic [15:0] exp,
                          input logic [7:0] exp_seg, input string req);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a;
    @(negedge clk);
    if (!to_mem) begin
      check({req, " R9 ready"}, ld_ready_o, 1);
      check({req, " data"}, ld_data_o, exp);
      check({req, " no mem ld"}, mem_ld_valid_o, 0);
    end else begin
      check({req, " R4 mem valid"}, mem_ld_valid_o, 1);
      check({req, " R4 mem addr"}, mem_ld_addr_o, {exp_seg, a});
      for (int i = 0; i < lat; i++) begin
        check({req, " R8 no early ready"}, ld_ready_o, 0);
        @(negedge clk);
      end
      mem_ld_ready = 1'b1; mem_ld_data = mdata;
      @(negedge clk);
      mem_ld_ready = 1'b0; mem_ld_data = '0;
      check({req, " R4 ready"}, ld_ready_o, 1);
      check({req, " R4 data"}, ld_data_o, mdata);
      check({req, " R4 mem dropped"}, mem_ld_valid_o, 0);
    end
    ld_valid = 1'b0;
  endtask

  task automatic cpu_store(input logic [15:0] a, input logic [15:0] d, input bit to_mem,
                           input int lat, input logic [7:0] exp_seg, input string req);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(negedge clk);
    if (!to_mem) begin
      check({req, " R9 ready"}, st_ready_o, 1);
      check({req, " no mem st"}, mem_st_valid_o, 0);
    end else begin
      check({req, " R7 mem valid"}, mem_st_valid_o, 1);
      check({req, " R7 mem addr"}, mem_st_addr_o, {exp_seg, a});
      check({req, " R7 mem data"}, mem_st_data_o, d);
      for (int i = 0; i < lat; i++) begin
        check({req, " R8 no early ready"}, st_ready_o, 0);
        @(negedge clk);
      end
      mem_st_ready = 1'b1;
      @(negedge clk);
      mem_st_ready = 1'b0;
      check({req, " R7 ready"}, st_ready_o, 1);
    end
    st_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ld_ready", ld_ready_o, 0);
    check("R1 st_ready", st_ready_o, 0);
    check("R1 mem_ld_valid", mem_ld_valid_o, 0);
    check("R1 mem_st_valid", mem_st_valid_o, 0);
    rst_n = 1'b1;
    cpu_load(16'hFFFF, 0, 0, 0, 16'h0000, 0, "R1 rseg reset");
    cpu_load(16'hFFFE, 0, 0, 0, 16'h0000, 0, "R1 wseg reset");

    // full sweep of segment values
    for (int v = 0; v < 256; v++) begin
      logic [7:0]  s  = 8'(v);
      logic [7:0]  ns = ~s;
      logic [15:0] va = {s, ns};
      logic [15:0] vb = va ^ 16'h5A5A;
      cpu_store(16'hFFFF, {ns, s}, 0, 0, 0, "R5 rseg write");
      cpu_store(16'hFFFE, {s, ns}, 0, 0, 0, "R6 wseg write");
      cpu_load(16'hFFFF, 0, 0, 0, {8'h00, s}, 0, "R2 rseg read");
      cpu_load(16'hFFFE, 0, 0, 0, {8'h00, ns}, 0, "R3 wseg read");
      cpu_load(va, 1, v % 4, 16'(v * 3 + 1), 0, s, "R4 mem load");
      cpu_store(vb, 16'(v * 7 + 5), 1, (v + 1) % 4, ns, "R7 mem store");
    end

    // boundary addresses next to the register slots
    cpu_store(16'hFFFF, 16'h12C3, 0, 0, 0, "R5 set rseg");
    cpu_store(16'hFFFE, 16'h3456, 0, 0, 0, "R6 set wseg");
    cpu_load(16'hFFFD, 1, 2, 16'hBEEF, 0, 8'hC3, "R4 boundary FFFD");
    cpu_load(16'h7FFF, 1, 0, 16'h1111, 0, 8'hC3, "R4 boundary 7FFF");
    cpu_store(16'h0000, 16'hCAFE, 1, 1, 8'h56, "R7 boundary 0000");
    cpu_store(16'hFFFC, 16'hF00D, 1, 0, 8'h56, "R7 boundary FFFC");

    // simultaneous requests: load served first
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 16'hFFFF;
    st_valid = 1'b1; st_addr = 16'hFFFE; st_data = 16'h00A7;
    @(negedge clk);
    check("R8 load first ready", ld_ready_o, 1);
    check("R8 store waits", st_ready_o, 0);
    check("R8 load data", ld_data_o, 16'h00C3);
    ld_valid = 1'b0;
    @(negedge clk);
    check("R8 store still waits", st_ready_o, 0);
    @(negedge clk);
    check("R8 store served", st_ready_o, 1);
    st_valid = 1'b0;
    cpu_load(16'hFFFE, 0, 0, 0, 16'h00A7, 0, "R6 wseg after arbitration");
    cpu_load(16'hFFFF, 0, 0, 0, 16'h00C3, 0, "R5 rseg untouched");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule